// File: doc/BRIEF.md
# Prescaled Cycle Counter

This block counts elapsed time in units that software chooses. A 32-bit down-counting prescaler runs on every clock. When it reaches zero, it reloads from a 32-bit reload register on the next edge, and in that same edge a 32-bit up counter advances by one. A reload value of N therefore gives one count every N+1 clocks. With a reload of zero, the up counter advances on every clock.

Software reaches all three registers through a plain word interface made of an address, a write strobe, write data and read data. A register write takes effect on the next rising clock edge. Read data is a combinational selection of the current register contents. Software can preset or clear the up counter. It can also load the live prescaler directly to shift the phase of the next count.

Top module: `pcc_top`

## Requirements
- R1: While reset is asserted, and on the first read after reset, the up counter, the reload register and the prescaler all read as zero.
- R2: With reload value N and no writes, the up counter advances by exactly one every N+1 clock cycles. With N = 0 it advances on every cycle.
- R3: While the prescaler is non-zero and not being written, it decreases by one on each clock.
- R4: On the clock edge that finds the prescaler at zero, the prescaler takes the reload value that was held before that edge, and the up counter increases by one.
- R5: A write to the prescaler loads the write data on the next edge. It overrides both decrement and reload. If the prescaler was zero in that cycle, the up counter does not advance.
- R6: A write to the up counter loads the write data on the next edge. In that same cycle the write wins over a pending increment.
- R7: The up counter wraps from 0xFFFFFFFF to 0 with no other effect.
- R8: A write to the reload register changes only that register. The live prescaler keeps counting down from its current value, and the new reload value is used at the next expiry.
- R9: The byte addresses are 0x10 for the up counter, 0x20 for the reload register and 0x24 for the prescaler. Any other address reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W (8) | Byte address of the register accessed |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data of the addressed register, combinational |

## Verification
Every write lands on the first rising edge after it is driven. The bench therefore drives a write just after a falling edge and reads the result after the following falling edge, at which point exactly one edge has passed. Reads involve no register stage, so each read sets the address and samples one time unit later within the same low phase. In that window the counting state cannot move. Expected prescaler and counter values are computed from the number of falling edges elapsed since a known write. For a reload of N, the prescaler is N minus (k mod (N+1)) and the counter has advanced by k div (N+1).

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    // Byte offsets of the three counting registers
    localparam int unsigned OFF_COUNT  = 32'h10;
    localparam int unsigned OFF_RELOAD = 32'h20;
    localparam int unsigned OFF_PRESC  = 32'h24;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_PRESC  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pcc_decode.sv
module pcc_decode
    import pcc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output reg_sel_e          sel_o,
    output logic              wr_count_o,
    output logic              wr_reload_o,
    output logic              wr_presc_o
);

    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
    localparam logic [ADDR_W-1:0] A_PRESC  = ADDR_W'(OFF_PRESC);

    always_comb begin
        unique case (addr_i)
            A_COUNT:  sel_o = SEL_COUNT;
            A_RELOAD: sel_o = SEL_RELOAD;
            A_PRESC:  sel_o = SEL_PRESC;
            default:  sel_o = SEL_NONE;
        endcase
    end

    assign wr_count_o  = we_i && (sel_o == SEL_COUNT);
    assign wr_reload_o = we_i && (sel_o == SEL_RELOAD);
    assign wr_presc_o  = we_i && (sel_o == SEL_PRESC);

endmodule

// File: rtl/pcc_prescaler.sv
module pcc_prescaler #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_reload_i,
    input  logic              wr_presc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] presc_o,
    output logic              tick_o
);

    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] presc;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic      expired;

    assign expired = (st_q.presc == '0);

    always_comb begin
        st_d = st_q;
        if (wr_reload_i) begin
            st_d.reload = wdata_i;
        end
        if (wr_presc_i) begin
            st_d.presc = wdata_i;
        end else if (expired) begin
            st_d.presc = st_q.reload;
        end else begin
            st_d.presc = st_q.presc - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // An expiry overridden by a prescaler write does not count
    assign tick_o   = expired && !wr_presc_i;
    assign reload_o = st_q.reload;
    assign presc_o  = st_q.presc;

    // R1
    reset_zero_ps_chk: assert property (@(posedge clk)
        !rst_n |-> (presc_o == '0 && reload_o == '0));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_presc_i && presc_o != '0) |=> presc_o == $past(presc_o) - 1'b1);

    // R4
    reload_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_presc_i && presc_o == '0) |=> presc_o == $past(reload_o));

    // R5
    presc_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_presc_i |=> presc_o == $past(wdata_i));

    // R8
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reload_i |=> $stable(reload_o));

endmodule

// File: rtl/pcc_upcount.sv
module pcc_upcount #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] count_o
);

    typedef struct packed {
        logic [DATA_W-1:0] count;
    } uc_state_t;

    uc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.count = wdata_i;
        end else if (tick_i) begin
            st_d.count = st_q.count + 1'b1;   // wraps silently
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

    // R1
    reset_zero_cnt_chk: assert property (@(posedge clk)
        !rst_n |-> count_o == '0);

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i) |=> count_o == $past(count_o) + 1'b1);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_i) |=> $stable(count_o));

    // R6
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> count_o == $past(wdata_i));

endmodule

// File: rtl/pcc_top.sv
module pcc_top
    import pcc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    reg_sel_e          sel;
    logic              wr_count, wr_reload, wr_presc;
    logic              tick;
    logic [DATA_W-1:0] count_v, reload_v, presc_v;

    pcc_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr_i      (reg_addr),
        .we_i        (reg_we),
        .sel_o       (sel),
        .wr_count_o  (wr_count),
        .wr_reload_o (wr_reload),
        .wr_presc_o  (wr_presc)
    );

    pcc_prescaler #(.DATA_W(DATA_W)) i_prescaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_reload_i (wr_reload),
        .wr_presc_i  (wr_presc),
        .wdata_i     (reg_wdata),
        .reload_o    (reload_v),
        .presc_o     (presc_v),
        .tick_o      (tick)
    );

    pcc_upcount #(.DATA_W(DATA_W)) i_upcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_i    (wr_count),
        .wdata_i (reg_wdata),
        .count_o (count_v)
    );

    always_comb begin
        unique case (sel)
            SEL_COUNT:  reg_rdata = count_v;
            SEL_RELOAD: reg_rdata = reload_v;
            SEL_PRESC:  reg_rdata = presc_v;
            default:    reg_rdata = '0;
        endcase
    end

    // R9
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_count, wr_reload, wr_presc}));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> reg_rdata == '0);

    // R5
    no_tick_on_presc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_presc && !wr_count) |=> $stable(count_v));

endmodule

// File: tb/test_pcc_top.sv
module test_pcc_top;

    localparam int unsigned PERIOD = 10;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam logic [ADDR_W-1:0] A_CNT = 8'h10;
    localparam logic [ADDR_W-1:0] A_REL = 8'h20;
    localparam logic [ADDR_W-1:0] A_PRE = 8'h24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    always #(PERIOD / 2) clk = ~clk;

    pcc_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pcc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a write in the low phase; returns after the next falling edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] v;
        step(1);
        rd(A_CNT, v); chk("R1 count in reset", v, 0);
        rd(A_REL, v); chk("R1 reload in reset", v, 0);
        rd(A_PRE, v); chk("R1 prescaler in reset", v, 0);
        step(1);
        rst_n = 1'b1;
        rd(A_CNT, v); chk("R1 count after release", v, 0);
        // reload 0: one count per cycle
        step(1);
        rd(A_CNT, v); chk("R2 N=0 one cycle", v, 1);
        step(2);
        rd(A_CNT, v); chk("R2 N=0 three cycles", v, 3);
        rd(A_PRE, v); chk("R2 N=0 prescaler stays zero", v, 0);
    endtask

    task automatic t_period;
        logic [DATA_W-1:0] v;
        wr(A_REL, 3);
        wr(A_CNT, 0);
        wr(A_PRE, 3);
        rd(A_PRE, v); chk("R5 prescaler loaded", v, 3);
        rd(A_CNT, v); chk("R6 counter cleared", v, 0);
        for (int k = 1; k <= 9; k++) begin
            step(1);
            rd(A_PRE, v); chk("R3 R4 prescaler sequence", v, 32'(3 - (k % 4)));
            rd(A_CNT, v); chk("R2 count every N+1", v, 32'(k / 4));
        end
    endtask

    task automatic t_presc_override;
        logic [DATA_W-1:0] v, c0;
        wr(A_REL, 5);
        wr(A_PRE, 0);
        rd(A_CNT, c0);
        wr(A_PRE, 7);   // lands on an edge that finds the prescaler at zero
        rd(A_PRE, v); chk("R5 write beats reload", v, 7);
        rd(A_CNT, v); chk("R5 no count on overridden expiry", v, c0);
        step(1);
        rd(A_PRE, v); chk("R5 counting resumes", v, 6);
        rd(A_CNT, v); chk("R5 count unchanged", v, c0);
    endtask

    task automatic t_count_preset;
        logic [DATA_W-1:0] v;
        wr(A_REL, 0);
        wr(A_PRE, 0);
        wr(A_CNT, 100);  // prescaler is zero: increment pending
        rd(A_CNT, v); chk("R6 write beats increment", v, 100);
        step(1);
        rd(A_CNT, v); chk("R6 counts from preset", v, 101);
    endtask

    task automatic t_wrap;
        logic [DATA_W-1:0] v;
        wr(A_CNT, 32'hFFFF_FFFF);
        rd(A_CNT, v); chk("R7 preset all ones", v, 32'hFFFF_FFFF);
        step(1);
        rd(A_CNT, v); chk("R7 wraps to zero", v, 0);
        step(1);
        rd(A_CNT, v); chk("R7 continues after wrap", v, 1);
    endtask

    task automatic t_reload_write;
        logic [DATA_W-1:0] v, c0;
        wr(A_REL, 2);
        wr(A_PRE, 10);
        rd(A_CNT, c0);
        wr(A_REL, 4);
        rd(A_REL, v); chk("R8 reload reads back", v, 4);
        rd(A_PRE, v); chk("R8 prescaler undisturbed", v, 9);
        step(9);
        rd(A_PRE, v); chk("R8 reached zero", v, 0);
        rd(A_CNT, v); chk("R8 no count yet", v, c0);
        step(1);
        rd(A_PRE, v); chk("R8 new reload used", v, 4);
        rd(A_CNT, v); chk("R8 count at expiry", v, c0 + 1);
    endtask

    task automatic t_map;
        logic [DATA_W-1:0] v;
        wr(A_REL, 32'h100);
        wr(A_CNT, 55);
        wr(A_PRE, 32'h1000);
        wr(8'h28, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h14, 32'hDEAD_BEEF);
        rd(A_REL, v); chk("R9 reload untouched", v, 32'h100);
        rd(A_PRE, v); chk("R9 prescaler untouched", v, 32'h1000 - 3);
        rd(A_CNT, v); chk("R9 counter untouched", v, 55);
        rd(8'h28, v); chk("R9 unmapped 0x28 reads zero", v, 0);
        rd(8'h00, v); chk("R9 unmapped 0x00 reads zero", v, 0);
        rd(8'h14, v); chk("R9 unmapped 0x14 reads zero", v, 0);
    endtask

    initial begin
        t_reset();
        t_period();
        t_presc_override();
        t_count_preset();
        t_wrap();
        t_reload_write();
        t_map();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule